// File: doc/BRIEF.md
# Quad-Lane Serial Flash Command Sequencer

This block lets software issue one complete serial flash transaction at a time through a small 32-bit register window. Software fills in an opcode, an address, up to sixteen outgoing bytes and a per-phase layout word. It then sets a start bit. The engine runs the transaction on a four-lane serial flash bus and stops. The lanes use SPI mode 0: the clock idles low, data changes while the clock is low, and data is sampled on the rising edge. Any incoming bytes land in four 32-bit read words.

A transaction has up to five phases, always in this order: a one-byte opcode, address bytes, dummy bytes, outgoing data and incoming data. A phase with a count of zero is skipped and produces no clocks. Each phase carries its own lane-width code, so one transaction can send a single-lane opcode, a dual-lane address and a quad-lane payload.

A chip-select hold control keeps the selected flash selected after a transaction ends. This lets software send a long page program as an opcode transaction followed by chained sixteen-byte payload transactions, and then release the select line. A sticky ready flag with an enable drives the interrupt output.

Top module: `qspi_xact_engine`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, the interrupt is low, the layout word (offset 0x08) reads 0 and the control word (offset 0x0C) reads 0x0001_0000, with the release bit set.
- R2: Writing 1 to control bit 0 while idle starts a transaction. Bit 0 reads 1 until the transaction ends and then reads 0. Writing 1 to bit 0 while busy starts nothing.
- R3: Phases run as opcode (when layout bit 10 is 1), address, dummy, outgoing data, incoming data. An empty phase emits no clocks. A transaction in which every phase is empty completes with no clock at all.
- R4: Each phase's lane code selects lanes as follows: 0 gives one lane (out on lane 0, in on lane 1), 1 gives lanes 1:0, and 2 or 3 gives lanes 3:0. Codes sit in layout bits 1:0 (opcode), 3:2 (address), 5:4 (outgoing), 7:6 (dummy) and 9:8 (incoming). Bits go out most significant first, and outgoing phases enable exactly the lanes in use.
- R5: The address byte count is layout bits 13:11, limited to 4. Bytes are taken from the low bytes of the address word (offset 0x14) and sent most significant first.
- R6: The dummy byte count is layout bits 23:21. During dummy bytes every lane is released, and each byte lasts 8 divided by its lane width clocks.
- R7: The outgoing byte count is layout bits 20:16, limited to 16. Byte k is read from byte lane k mod 4 of the data word at offset 0x20 + 4*(k/4), with lane 0 in bits 7:0.
- R8: The incoming byte count is layout bits 28:24, limited to 16. All lanes are released while bytes come in. Byte k is stored in lane k mod 4 of the word at offset 0x30 + 4*(k/4).
- R9: Control bits 9:8 pick the chip-select line. It is low while busy. It stays low after completion while control bit 16 is 0, and goes high once bit 16 is 1. At most one line is low at any time.
- R10: Control bit 24 (ready) sets when a transaction completes and clears when 1 is written to it. The interrupt equals ready AND control bit 25.
- R11: While busy, writes to the layout, opcode, address and outgoing data words, and to the select and release bits, have no effect.
- R12: Each half period of the serial clock lasts HALF_DIV system clocks, so rising edges within a transaction are 2*HALF_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Completion interrupt |
| sck | output | 1 | Serial clock |
| cs_n | output | NCS | Active-low chip selects |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The hardest situation to reach is a register write that arrives while a transaction is already running. To get there, the stimulus issues the start, then immediately rewrites the layout, the select, the release bit and the start bit with conflicting values. It then checks that the serial stream, the active select line and the layout read-back all match the values captured before the start. A second hard case is the chained select hold, which spans two transactions with the select held low in between; a scripted sequence of a hold-on opcode transaction, a payload transaction and a final release reaches it. A scoreboard holds every expected lane slot and compares them in order, and a responder replays incoming nibbles on the same clock edges. Together they catch reordered phases, wrong lane widths and lost bytes.

// File: rtl/qxe_pkg.sv
package qxe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0, PH_CMD = 3'd1, PH_ADDR = 3'd2,
    PH_DUM  = 3'd3, PH_WR  = 3'd4, PH_RD   = 3'd5
  } phase_t;

  typedef struct packed {
    logic [4:0] rd_n;
    logic [2:0] dum_n;
    logic [4:0] wr_n;
    logic [2:0] addr_n;
    logic       cmd_en;
    logic [1:0] rd_c;
    logic [1:0] dum_c;
    logic [1:0] wr_c;
    logic [1:0] ad_c;
    logic [1:0] cm_c;
  } layout_t;

  // lanes carried per serial clock for a lane code
  function automatic logic [3:0] lane_bits(logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [4:0] clamp_cnt(logic [4:0] raw, logic [4:0] lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // first non-empty phase after cur; PH_IDLE when none is left
  function automatic phase_t next_phase(phase_t cur, logic [4:0] act);
    phase_t r = PH_IDLE;
    for (int k = 1; k <= 5; k++)
      if (r == PH_IDLE && k > int'(cur) && act[k-1]) r = phase_t'(3'(k));
    return r;
  endfunction
endpackage

// File: rtl/qxe_regs.sv
module qxe_regs
  import qxe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [7:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          done,
  input  logic          rd_we,
  input  logic [3:0]    rd_idx,
  input  logic [7:0]    rd_byte,
  output logic          go,
  output logic          busy,
  output layout_t       lay,
  output logic [7:0]    cmd_op,
  output logic [31:0]   addr_word,
  output logic [127:0]  wflat,
  output logic [1:0]    dev,
  output logic          rel,
  output logic          irq
);
  logic [127:0] rflat;
  logic rdy, ie;
  logic wr_ok, wr_cts;

  assign wr_ok  = wr && (addr[1:0] == 2'b00);
  assign wr_cts = wr_ok && (addr[7:2] == 6'h03);
  assign go     = wr_cts && wdata[0] && !busy;
  assign irq    = rdy && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lay <= '0; cmd_op <= '0; addr_word <= '0; wflat <= '0; rflat <= '0;
      busy <= 1'b0; rdy <= 1'b0; ie <= 1'b0; dev <= '0; rel <= 1'b1;
    end else begin
      if (go) busy <= 1'b1;
      if (done) busy <= 1'b0;
      if (done) rdy <= 1'b1;
      else if (wr_cts && wdata[24]) rdy <= 1'b0;
      if (wr_cts) ie <= wdata[25];
      if (wr_cts && !busy) begin
        dev <= wdata[9:8];
        rel <= wdata[16];
      end
      if (wr_ok && !busy) begin
        if (addr[7:2] == 6'h02)
          lay <= {wdata[28:24], wdata[23:21], wdata[20:16], wdata[13:11], wdata[10:0]};
        if (addr[7:2] == 6'h04) cmd_op <= wdata[7:0];
        if (addr[7:2] == 6'h05) addr_word <= wdata;
        if (addr[7:4] == 4'h2) wflat[{addr[3:2], 5'd0} +: 32] <= wdata;
      end
      if (rd_we) rflat[{rd_idx, 3'd0} +: 8] <= rd_byte;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr[7:4])
      4'h0: begin
        if (addr[3:2] == 2'd2)
          rdata = {3'b0, lay.rd_n, lay.dum_n, lay.wr_n, 2'b0, lay.addr_n, lay.cmd_en,
                   lay.rd_c, lay.dum_c, lay.wr_c, lay.ad_c, lay.cm_c};
        if (addr[3:2] == 2'd3)
          rdata = {6'b0, ie, rdy, 7'b0, rel, 6'b0, dev, 7'b0, busy};
      end
      4'h1: begin
        if (addr[3:2] == 2'd0) rdata = {24'b0, cmd_op};
        if (addr[3:2] == 2'd1) rdata = addr_word;
      end
      4'h2: rdata = wflat[{addr[3:2], 5'd0} +: 32];
      4'h3: rdata = rflat[{addr[3:2], 5'd0} +: 32];
      default: rdata = '0;
    endcase
  end

  // R11: layout frozen for every cycle that follows a busy cycle
  a_r11_layout_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(lay));
  // R10: completion leaves the ready flag set
  a_r10_ready_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rdy);
endmodule

// File: rtl/qxe_seq.sv
module qxe_seq
  import qxe_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  layout_t       lay,
  input  logic [7:0]    cmd_op,
  input  logic [31:0]   addr_word,
  input  logic [127:0]  wflat,
  input  logic [3:0]    io_in,
  output logic          sck,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  output logic          done,
  output logic          rd_we,
  output logic [3:0]    rd_idx,
  output logic [7:0]    rd_byte
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  phase_t ph, first_ph, after_ph, tgt_ph;
  logic [3:0] idx, tgt_idx, left, w;
  logic [7:0] sh, tgt_byte, sh_in, sh_out;
  logic [DW-1:0] div;
  logic [4:0] n_addr, n_wr, n_rd, n_cur, act;
  logic [1:0] code, ab;
  logic tick, rise, fall, byte_end, last_byte, drive;

  assign n_addr = clamp_cnt({2'b0, lay.addr_n}, 5'd4);
  assign n_wr   = clamp_cnt(lay.wr_n, 5'd16);
  assign n_rd   = clamp_cnt(lay.rd_n, 5'd16);
  assign act    = {n_rd != 0, n_wr != 0, lay.dum_n != 0, n_addr != 0, lay.cmd_en};
  assign first_ph = next_phase(PH_IDLE, act);
  assign after_ph = next_phase(ph, act);

  always_comb begin
    case (ph)
      PH_CMD:  begin n_cur = 5'd1;               code = lay.cm_c;  end
      PH_ADDR: begin n_cur = n_addr;             code = lay.ad_c;  end
      PH_DUM:  begin n_cur = {2'b0, lay.dum_n};  code = lay.dum_c; end
      PH_WR:   begin n_cur = n_wr;               code = lay.wr_c;  end
      PH_RD:   begin n_cur = n_rd;               code = lay.rd_c;  end
      default: begin n_cur = 5'd1;               code = 2'd0;      end
    endcase
  end

  assign w         = lane_bits(code);
  assign tick      = (ph != PH_IDLE) && (div == DW'(HALF_DIV - 1));
  assign rise      = tick && !sck;
  assign fall      = tick && sck;
  assign byte_end  = fall && (left == w);
  assign last_byte = ({1'b0, idx} + 5'd1) >= n_cur;

  always_comb begin
    if (go)             begin tgt_ph = first_ph; tgt_idx = '0; end
    else if (last_byte) begin tgt_ph = after_ph; tgt_idx = '0; end
    else                begin tgt_ph = ph;       tgt_idx = idx + 4'd1; end
    ab = 2'(n_addr - 5'd1 - {1'b0, tgt_idx});
    case (tgt_ph)
      PH_CMD:  tgt_byte = cmd_op;
      PH_ADDR: tgt_byte = 8'(addr_word >> {ab, 3'b000});
      PH_WR:   tgt_byte = wflat[{tgt_idx, 3'b000} +: 8];
      default: tgt_byte = 8'h00;
    endcase
  end

  always_comb begin
    case (w)
      4'd1: begin sh_in = {sh[6:0], io_in[1]};   sh_out = {sh[6:0], 1'b0};  end
      4'd2: begin sh_in = {sh[5:0], io_in[1:0]}; sh_out = {sh[5:0], 2'b0};  end
      default: begin sh_in = {sh[3:0], io_in};   sh_out = {sh[3:0], 4'b0};  end
    endcase
    drive = (ph == PH_CMD) || (ph == PH_ADDR) || (ph == PH_WR);
    io_oe  = '0;
    io_out = '0;
    if (drive) begin
      case (w)
        4'd1:    begin io_oe = 4'b0001; io_out = {3'b0, sh[7]};   end
        4'd2:    begin io_oe = 4'b0011; io_out = {2'b0, sh[7:6]}; end
        default: begin io_oe = 4'b1111; io_out = sh[7:4];         end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; idx <= '0; sh <= '0; left <= '0; sck <= 1'b0; div <= '0;
    end else if (go) begin
      ph <= tgt_ph; idx <= tgt_idx; sh <= tgt_byte; left <= 4'd8;
      sck <= 1'b0; div <= '0;
    end else if (ph != PH_IDLE) begin
      div <= tick ? '0 : div + 1'b1;
      if (rise) begin
        sck <= 1'b1;
        if (ph == PH_RD) sh <= sh_in;
      end
      if (fall) begin
        sck <= 1'b0;
        if (byte_end) begin
          ph <= tgt_ph; idx <= tgt_idx; sh <= tgt_byte; left <= 4'd8;
        end else begin
          left <= left - w;
          if (ph != PH_RD) sh <= sh_out;
        end
      end
    end
  end

  assign done    = (go && first_ph == PH_IDLE) || (byte_end && last_byte && after_ph == PH_IDLE);
  assign rd_we   = byte_end && (ph == PH_RD);
  assign rd_idx  = idx;
  assign rd_byte = sh;

  // R12: the serial clock only runs inside a transaction
  a_r12_clock_in_xact: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> ph != PH_IDLE);
  // R3: no clock edge follows the end of a transaction
  a_r3_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !sck);
  // R8: incoming bytes are stored only while every lane is released
  a_r8_store_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> io_oe == 4'b0000);
endmodule

// File: rtl/qspi_xact_engine.sv
module qspi_xact_engine
  import qxe_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int HALF_DIV = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq,
  output logic            sck,
  output logic [NCS-1:0]  cs_n,
  output logic [3:0]      io_out,
  output logic [3:0]      io_oe,
  input  logic [3:0]      io_in
);
  layout_t lay;
  logic [7:0] cmd_op, rd_byte;
  logic [31:0] addr_word;
  logic [127:0] wflat;
  logic [3:0] rd_idx;
  logic [1:0] dev;
  logic go, busy, done, rd_we, rel, sel_on;

  qxe_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done(done), .rd_we(rd_we), .rd_idx(rd_idx), .rd_byte(rd_byte),
    .go(go), .busy(busy), .lay(lay), .cmd_op(cmd_op), .addr_word(addr_word),
    .wflat(wflat), .dev(dev), .rel(rel), .irq(irq)
  );

  qxe_seq #(.HALF_DIV(HALF_DIV)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .lay(lay), .cmd_op(cmd_op),
    .addr_word(addr_word), .wflat(wflat), .io_in(io_in), .sck(sck),
    .io_out(io_out), .io_oe(io_oe), .done(done), .rd_we(rd_we),
    .rd_idx(rd_idx), .rd_byte(rd_byte)
  );

  assign sel_on = busy || !rel;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(sel_on && dev == 2'(i));
  end

  // R9: never more than one flash selected
  a_r9_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
endmodule

// File: tb/qspi_xact_engine_test.sv
module qspi_xact_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, sck;
  logic [3:0] cs_n, io_out, io_oe;
  logic [3:0] io_in = '0;

  int tests = 0, fails = 0, mism = 0, quiet = 0;
  logic [7:0] exp_q[$];
  logic [3:0] in_q[$];
  logic [7:0] wb[16], rb[16];
  time last_rise = 0, per = 0;

  qspi_xact_engine #(.NCS(4), .HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck),
    .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares driven slots, responder: feeds released slots
  always @(posedge sck) begin
    per = $time - last_rise;
    last_rise = $time;
    if (io_oe != 4'b0) begin
      if (exp_q.size() == 0) mism++;
      else begin
        logic [7:0] it;
        it = exp_q.pop_front();
        if ({io_oe, io_out & io_oe} != it) mism++;
      end
    end else begin
      quiet++;
      if (in_q.size() != 0) void'(in_q.pop_front());
      io_in = (in_q.size() != 0) ? in_q[0] : 4'h0;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic int lanes(logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  task automatic push_out(logic [7:0] b, logic [1:0] c);
    int n = lanes(c);
    for (int s = 0; s < 8 / n; s++) begin
      logic [7:0] v = b << (s * n);
      if (n == 1) exp_q.push_back({4'b0001, 3'b0, v[7]});
      else if (n == 2) exp_q.push_back({4'b0011, 2'b0, v[7:6]});
      else exp_q.push_back({4'b1111, v[7:4]});
    end
  endtask

  task automatic push_in(logic [7:0] b, logic [1:0] c);
    int n = lanes(c);
    for (int s = 0; s < 8 / n; s++) begin
      logic [7:0] v = b << (s * n);
      if (n == 1) in_q.push_back({2'b0, v[7], 1'b0});
      else if (n == 2) in_q.push_back({2'b0, v[7:6]});
      else in_q.push_back(v[7:4]);
    end
  endtask

  function automatic logic [31:0] mkcfg(bit en, logic [1:0] cc, ac, wc, dc, rc,
                                        logic [2:0] na, nd, logic [4:0] nw, nr);
    return {3'b0, nr, nd, nw, 2'b0, na, en, rc, dc, wc, ac, cc};
  endfunction

  // run one transaction; meddle adds conflicting writes while busy (R11, R2)
  task automatic xact(logic [31:0] cfg, logic [7:0] cmd, logic [31:0] adr,
                      logic [31:0] cts, bit meddle, string name);
    int na, nd, nw, nr, qexp;
    logic [31:0] d;
    bit empty;
    exp_q.delete(); in_q.delete(); mism = 0; quiet = 0;
    na = (cfg[13:11] > 4) ? 4 : int'(cfg[13:11]);
    nd = int'(cfg[23:21]);
    nw = (cfg[20:16] > 16) ? 16 : int'(cfg[20:16]);
    nr = (cfg[28:24] > 16) ? 16 : int'(cfg[28:24]);
    empty = !cfg[10] && na == 0 && nd == 0 && nw == 0 && nr == 0;
    wr(8'h08, cfg); wr(8'h10, {24'b0, cmd}); wr(8'h14, adr);
    for (int j = 0; j < 4; j++)
      wr(8'h20 + 8'(4 * j), {wb[4*j+3], wb[4*j+2], wb[4*j+1], wb[4*j]});
    if (cfg[10]) push_out(cmd, cfg[1:0]);
    for (int i = 0; i < na; i++) push_out(8'(adr >> (8 * (na - 1 - i))), cfg[3:2]);
    for (int i = 0; i < nd; i++) push_in(8'h00, cfg[7:6]);
    for (int i = 0; i < nw; i++) push_out(wb[i], cfg[5:4]);
    for (int i = 0; i < nr; i++) push_in(rb[i], cfg[9:8]);
    qexp = nd * 8 / lanes(cfg[7:6]) + nr * 8 / lanes(cfg[9:8]);
    io_in = (in_q.size() != 0) ? in_q[0] : 4'h0;
    wr(8'h0C, cts | 32'h0100_0001);
    if (!empty) begin
      check(cs_n[cts[9:8]] == 1'b0, {"R9 select low while busy ", name}, 32'(cs_n), 32'(cts[9:8]));
      rd(8'h0C, d);
      check(d[0] == 1'b1, {"R2 busy after start ", name}, d, 32'h1);
    end
    if (meddle) begin
      wr(8'h08, 32'h0000_0000);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h20, 32'h0000_0000);
      wr(8'h0C, 32'h0000_0301);
      check(cs_n[cts[9:8]] == 1'b0, "R2 restart while busy ignored", 32'(cs_n), 32'(cts[9:8]));
    end
    for (int k = 0; k < 20000; k++) begin
      rd(8'h0C, d);
      if (d[0] == 1'b0) break;
    end
    check(d[0] == 1'b0 && d[24] == 1'b1, {"R2 done and ready ", name}, d, 32'h0100_0000);
    check(mism == 0, {"R4 lane slots ", name}, 32'(mism), 0);
    check(exp_q.size() == 0, {"R3 phase stream complete ", name}, 32'(exp_q.size()), 0);
    check(quiet == qexp, {"R6 released slot count ", name}, 32'(quiet), 32'(qexp));
    for (int j = 0; j < (nr + 3) / 4; j++) begin
      rd(8'h30 + 8'(4 * j), d);
      for (int b = 0; b < 4; b++)
        if (4 * j + b < nr)
          check(d[8*b +: 8] == rb[4*j+b], {"R8 incoming byte ", name}, 32'(d[8*b +: 8]), 32'(rb[4*j+b]));
    end
    if (meddle) begin
      rd(8'h08, d);
      check(d == cfg, "R11 layout write while busy ignored", d, cfg);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin wb[i] = 8'(8'h5A ^ (i * 29)); rb[i] = 8'(i * 17 + 3); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(cs_n == 4'hF && sck == 1'b0 && irq == 1'b0, "R1 pins at reset", {cs_n, sck, irq}, 32'h3C);
    rd(8'h0C, d); check(d == 32'h0001_0000, "R1 control word at reset", d, 32'h0001_0000);
    rd(8'h08, d); check(d == 32'h0, "R1 layout word at reset", d, 0);

    // R3 R4 R8: single-lane opcode then three incoming bytes
    rb[0] = 8'hC2; rb[1] = 8'h20; rb[2] = 8'h18;
    xact(mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 3), 8'h9F, 32'h0, 32'h0001_0000, 0, "id read");
    check(per == time'(2 * HALF * CLK_PERIOD), "R12 serial clock period", 32'(per), 32'(2 * HALF * CLK_PERIOD));

    // R5 R7 R4: dual address of 3 bytes, quad payload of 5 bytes
    xact(mkcfg(1, 0, 1, 2, 0, 0, 3, 0, 5, 0), 8'h32, 32'h00A1_B2C3, 32'h0001_0100, 0, "quad program");

    // R6 R8 R4: quad everything, 4 address, 2 dummy, 16 incoming with code 3
    for (int i = 0; i < 16; i++) rb[i] = 8'(i * 17 + 3);
    xact(mkcfg(1, 2, 2, 0, 2, 3, 4, 2, 0, 16), 8'hEB, 32'h1234_5678, 32'h0001_0000, 0, "quad read");

    // R5 R7 clamps, R11 R2 writes while busy
    xact(mkcfg(1, 0, 1, 1, 0, 0, 7, 0, 20, 0), 8'h02, 32'h0BAD_F00D, 32'h0001_0000, 1, "clamped");

    // R9 chained hold on line 2
    xact(mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0), 8'h06, 32'h0, 32'h0000_0200, 0, "hold cmd");
    check(cs_n == 4'b1011, "R9 select held after done", 32'(cs_n), 32'hB);
    xact(mkcfg(0, 0, 0, 0, 0, 0, 0, 0, 4, 0), 8'h00, 32'h0, 32'h0000_0200, 0, "hold data");
    check(cs_n == 4'b1011, "R9 select held after chained data", 32'(cs_n), 32'hB);
    wr(8'h0C, 32'h0001_0200);
    check(cs_n == 4'hF, "R9 select released", 32'(cs_n), 32'hF);

    // R10 interrupt enable and clear
    xact(mkcfg(1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 8'h05, 32'h0, 32'h0201_0000, 0, "irq");
    check(irq == 1'b1, "R10 interrupt raised", 32'(irq), 1);
    wr(8'h0C, 32'h0301_0000);
    rd(8'h0C, d);
    check(irq == 1'b0 && d[24] == 1'b0, "R10 ready cleared by write", d, 32'h0201_0000);
    xact(mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0), 8'h05, 32'h0, 32'h0001_0000, 0, "irq off");
    check(irq == 1'b0, "R10 interrupt masked", 32'(irq), 0);

    // R3 empty transaction
    xact(32'h0, 8'h00, 32'h0, 32'h0001_0000, 0, "empty");
    check(quiet == 0 && sck == 1'b0, "R3 no clocks when empty", 32'(quiet), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule